// File: doc/BRIEF.md
# Time-Aligned Square Wave Generator

This block drives a square wave on one output pin, with every edge placed against an external 64-bit nanosecond time counter rather than derived from a clock divider. A configuration request carries a full period and a 64-bit requested start time. The block checks the period and records the half period. It then works out the start instant and arms the wave. The pin stays low until the counter reaches the armed target, goes high, and flips every half period after that, measured on the same counter.

The requested start may already lie in the past. In that case the block moves it to the first whole second that is at least one millisecond after the current time, and adds the requested phase (start modulo period). Every target is pulled one nanosecond early to cover the output propagation delay. Both modulo and seconds computations use a single shared iterative divider, with a busy flag shown while it runs. A request with the enable low returns the pin to a non-driving idle state and clears the stored half period and target.

Top module: `tgt_wave_gen`

## Requirements
- R1: After reset, wave_oe, wave_out, busy and cfg_err are 0, and half_ns and target_ns read 0.
- R2: An enable request with an odd cfg_period sets cfg_err, leaves wave_oe at 0 and does not raise busy.
- R3: An enable request is rejected (cfg_err=1, wave_oe=0, no busy) when cfg_period/2 is not greater than MIN_PULSE (default 8) or exceeds 2^32-1; a half period of exactly 2^32-1 is accepted.
- R4: An accepted enable request clears cfg_err, loads half_ns with cfg_period/2, and holds wave_oe at 0 for as long as busy is high.
- R5: When cfg_start is not earlier than now_ns, busy stays high for 64 cycles and target_ns then equals cfg_start - 1.
- R6: When cfg_start is earlier than now_ns, busy stays high for 128 cycles. target_ns then equals ceil((now_ns + 1,000,000) / 1,000,000,000) x 1,000,000,000 + (cfg_start mod cfg_period) - 1.
- R7: Once armed, wave_oe is 1. wave_out is 0 while the sampled now_ns is below target_ns. With T the target and H the half period, wave_out is 1 one cycle after a sample with now_ns >= T, and 1 exactly when floor((now_ns - T)/H) is even.
- R8: If now_ns jumps past several edges at once, wave_out changes at most once and settles to the level given by the R7 rule for the new time.
- R9: A request with cfg_en=0 sets half_ns and target_ns to 0 and drives wave_oe, wave_out and cfg_err to 0 in the next cycle.
- R10: A request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_ns | input | TW | Current time counter in nanoseconds |
| cfg_go | input | 1 | One-cycle configuration request |
| cfg_en | input | 1 | 1 to enable with the given settings, 0 to disable |
| cfg_period | input | TW | Full period in nanoseconds |
| cfg_start | input | TW | Requested start time in nanoseconds |
| busy | output | 1 | Divider running; requests are ignored |
| cfg_err | output | 1 | Last request was rejected |
| half_ns | output | HW | Stored half period |
| target_ns | output | TW | Stored start target (delay-compensated) |
| wave_oe | output | 1 | Pin driven when 1 |
| wave_out | output | 1 | Square wave level |

## Verification
Every output is registered. A request sampled at one rising edge therefore shows cfg_err, half_ns and busy by the next falling edge, where the bench reads them. busy falls 64 cycles after the request, or 128 when the start has to be realigned, and target_ns is read at the first falling edge with busy low. The wave level changes one cycle after a time value is sampled. The bench changes now_ns only at falling edges and checks the level against the value held over the preceding rising edge, before it advances the time again.

// File: rtl/tgt_wave_gen.sv
module tgt_wave_gen #(
  parameter int TW = 64,
  parameter int HW = 32,
  parameter int MIN_PULSE = 8,
  parameter logic [TW-1:0] SEC_NS = TW'(1_000_000_000),
  parameter logic [TW-1:0] LEAD_NS = TW'(1_000_000),
  parameter logic [TW-1:0] PROP_NS = TW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] now_ns,
  input  logic          cfg_go,
  input  logic          cfg_en,
  input  logic [TW-1:0] cfg_period,
  input  logic [TW-1:0] cfg_start,
  output logic          busy,
  output logic          cfg_err,
  output logic [HW-1:0] half_ns,
  output logic [TW-1:0] target_ns,
  output logic          wave_oe,
  output logic          wave_out
);
  localparam int CW = $clog2(TW);

  typedef enum logic [1:0] {S_IDLE, S_PHASE, S_SEC} st_t;
  st_t st;

  logic [TW-1:0] dvd, dvs, rem, quo, start_q, phase_q, edge_t;
  logic [CW-1:0] cnt;
  logic [HW-1:0] half_q;
  logic [TW-1:0] tgt_q;
  logic          active, par, out_q, err_q;

  // configuration checks
  logic [TW-1:0] half_full;
  logic          bad_cfg;
  assign half_full = cfg_period >> 1;
  assign bad_cfg = cfg_period[0] || (half_full <= TW'(MIN_PULSE)) || (|half_full[TW-1:HW]);

  // one restoring division step
  logic [TW:0]   rsh;
  logic          ge;
  logic [TW-1:0] rem_n, quo_n;
  assign rsh   = {rem, dvd[TW-1]};
  assign ge    = rsh >= {1'b0, dvs};
  assign rem_n = ge ? TW'(rsh - {1'b0, dvs}) : rsh[TW-1:0];
  assign quo_n = {quo[TW-2:0], ge};

  logic          last;
  logic [TW-1:0] sec_start;
  assign last      = cnt == CW'(TW - 1);
  assign sec_start = quo_n * SEC_NS + phase_q;

  // edge scheduling
  logic [TW-1:0] nxt;
  logic          hit;
  assign nxt = edge_t + TW'(half_q);
  assign hit = now_ns >= edge_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dvd <= '0; dvs <= '0; rem <= '0; quo <= '0; cnt <= '0;
      start_q <= '0; phase_q <= '0; edge_t <= '0;
      half_q <= '0; tgt_q <= '0;
      active <= 1'b0; par <= 1'b0; out_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (cfg_go) begin
            active <= 1'b0;
            out_q  <= 1'b0;
            if (!cfg_en) begin
              half_q <= '0;
              tgt_q  <= '0;
              err_q  <= 1'b0;
            end else if (bad_cfg) begin
              err_q <= 1'b1;
            end else begin
              err_q   <= 1'b0;
              half_q  <= half_full[HW-1:0];
              start_q <= cfg_start;
              dvd     <= cfg_start;
              dvs     <= cfg_period;
              rem     <= '0;
              quo     <= '0;
              cnt     <= '0;
              st      <= S_PHASE;
            end
          end else if (active && hit) begin
            edge_t <= nxt;
            par    <= ~par;
            if (now_ns < nxt) out_q <= ~par;
          end
        end
        default: begin
          dvd <= dvd << 1;
          rem <= rem_n;
          quo <= quo_n;
          cnt <= cnt + 1'b1;
          if (last) begin
            if (st == S_PHASE && start_q < now_ns) begin
              phase_q <= rem_n;
              dvd <= now_ns + LEAD_NS + SEC_NS - TW'(1);
              dvs <= SEC_NS;
              rem <= '0;
              quo <= '0;
              cnt <= '0;
              st  <= S_SEC;
            end else begin
              tgt_q  <= (st == S_PHASE) ? start_q - PROP_NS : sec_start - PROP_NS;
              edge_t <= (st == S_PHASE) ? start_q - PROP_NS : sec_start - PROP_NS;
              par    <= 1'b0;
              out_q  <= 1'b0;
              active <= 1'b1;
              st     <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  assign busy      = st != S_IDLE;
  assign cfg_err   = err_q;
  assign half_ns   = half_q;
  assign target_ns = tgt_q;
  assign wave_oe   = active;
  assign wave_out  = out_q & active;
endmodule

// File: rtl/tgt_wave_gen_chk.sv
module tgt_wave_gen_chk #(
  parameter int TW = 64,
  parameter int HW = 32,
  parameter int MIN_PULSE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_go,
  input logic          cfg_en,
  input logic          busy,
  input logic          cfg_err,
  input logic [HW-1:0] half_ns,
  input logic [TW-1:0] target_ns,
  input logic          wave_oe,
  input logic          wave_out
);
  assert_quiet_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wave_oe);

  assert_idle_pin_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wave_oe |-> !wave_out);

  assert_reject_stays_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> (!wave_oe && !busy));

  assert_half_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wave_oe |-> (half_ns > HW'(MIN_PULSE)));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_go && !cfg_en && !busy) |=> (half_ns == '0 && target_ns == '0 && !wave_oe && !cfg_err));
endmodule

bind tgt_wave_gen tgt_wave_gen_chk #(.TW(TW), .HW(HW), .MIN_PULSE(MIN_PULSE)) u_chk (.*);

// File: tb/sim_tgt_wave_gen.sv
module sim_tgt_wave_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] now_ns = '0;
  logic        cfg_go = 1'b0, cfg_en = 1'b0;
  logic [63:0] cfg_period = '0, cfg_start = '0;
  logic        busy, cfg_err, wave_oe, wave_out;
  logic [31:0] half_ns;
  logic [63:0] target_ns;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tgt_wave_gen u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit lvl(input logic [63:0] t, input logic [63:0] h, input logic [63:0] n);
    if (n < t) return 1'b0;
    return ((n - t) / h) % 2 == 0;
  endfunction

  task automatic do_cfg(input bit en, input logic [63:0] per, input logic [63:0] st, output int cyc);
    @(negedge clk);
    cfg_en = en; cfg_period = per; cfg_start = st; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 oe", wave_oe, 0);
    chk("R1 out", wave_out, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 half", half_ns, 0);
    chk("R1 target", target_ns, 0);
  endtask

  task automatic t_reject;
    int c;
    do_cfg(1, 41, 500, c);
    chk("R2 err odd", cfg_err, 1);
    chk("R2 oe odd", wave_oe, 0);
    chk("R2 no busy", c, 0);
    do_cfg(1, 16, 500, c);
    chk("R3 err min", cfg_err, 1);
    chk("R3 busy min", c, 0);
    do_cfg(1, 64'h2_0000_0000, 500, c);
    chk("R3 err big", cfg_err, 1);
    chk("R3 oe big", wave_oe, 0);
  endtask

  task automatic t_accept;
    int c;
    do_cfg(1, 18, 500, c);
    chk("R4 err cleared", cfg_err, 0);
    chk("R4 half", half_ns, 9);
    chk("R5 busy cycles", c, 64);
    chk("R5 target", target_ns, 499);
    chk("R7 oe armed", wave_oe, 1);
    do_cfg(1, 64'h1_FFFF_FFFE, 500, c);
    chk("R3 max half ok", cfg_err, 0);
    chk("R3 max half", half_ns, 32'hFFFF_FFFF);
  endtask

  task automatic t_disable;
    int c;
    do_cfg(0, 0, 0, c);
    chk("R9 half", half_ns, 0);
    chk("R9 target", target_ns, 0);
    chk("R9 oe", wave_oe, 0);
    chk("R9 out", wave_out, 0);
    chk("R9 err", cfg_err, 0);
  endtask

  task automatic t_run;
    int c;
    now_ns = 0;
    do_cfg(1, 40, 1000, c);
    chk("R5 busy run", c, 64);
    chk("R5 target run", target_ns, 999);
    chk("R7 low before", wave_out, 0);
    now_ns = 900;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      chk("R7 level", wave_out, lvl(999, 20, now_ns));
      now_ns = now_ns + 4;
    end
  endtask

  task automatic t_jump;
    int changes = 0;
    logic prev;
    @(negedge clk);
    prev = wave_out;
    now_ns = now_ns + 110;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (wave_out !== prev) changes++;
      prev = wave_out;
    end
    chk("R8 single change", changes <= 1, 1);
    chk("R8 settled level", wave_out, lvl(999, 20, now_ns));
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    now_ns = 0;
    cfg_en = 1; cfg_period = 40; cfg_start = 2000; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    repeat (5) @(negedge clk);
    cfg_en = 0; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    chk("R10 still on", wave_oe, 1);
    chk("R10 half kept", half_ns, 20);
    chk("R10 target", target_ns, 1999);
  endtask

  task automatic t_past;
    int c;
    now_ns = 64'd3_500_000_000;
    do_cfg(1, 40, 123, c);
    chk("R6 busy cycles", c, 128);
    chk("R6 target", target_ns, 64'd4_000_000_002);
    chk("R6 low", wave_out, 0);
    now_ns = 64'd2_999_000_000;
    do_cfg(1, 40, 10, c);
    chk("R6 target exact second", target_ns, 64'd3_000_000_009);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reject();
    t_accept();
    t_disable();
    t_run();
    t_jump();
    t_disable();
    t_busy_ignore();
    t_past();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule